// File: doc/BRIEF.md
# Reset and Bus Clock Sequencer

This block is the reset and clock-gating controller of a small microcontroller. It runs on the selected source clock, which is either the crystal or the PLL output; that choice is made upstream. The raw crystal cycles reach the block as a one-cycle strobe, `osc_tick`, that is synchronous to that clock. The block divides the source clock by four. It produces two single-cycle bus enables, spaced two cycles apart, so that the CPU and the peripherals stay in one clock domain.

Five reset requests feed the block: power-on, low supply, watchdog, illegal opcode and illegal address. A power-on or low-supply request starts the long timeout. The block keeps every bus enable quiet and pulls the external reset pin low until 4096 raw oscillator ticks have been counted. The other three sources start a short reset of 32 ticks instead. The block keeps a sticky record of which sources caused a reset. A read strobe clears that record. While any reset is in progress, the block forces the oscillator-enable output high so that the tick strobe keeps arriving.

Top module: `rst_clk_seq`

## Requirements
- R1: Outside reset, `bus_ph1` is high for one cycle in every four, starting on the first cycle after release. `bus_ph2` is high exactly two cycles after each `bus_ph1`, and the two are never high together.
- R2: While `sys_rst` is high, neither bus enable is asserted.
- R3: While `por_req` is high, the block is held in reset with `reset_cause` = 5'b00001. After `por_req` falls, `rst_pin_n` stays low for exactly 4096 tick-cycles, measured with the tick present every cycle.
- R4: A `lvi_req` seen on a clock edge starts a long timeout, or restarts it from zero if one is running. A second request 1000 cycles into a timeout therefore gives a low period of 5096 cycles.
- R5: `rst_pin_n` is the inverse of `sys_rst`. Both are released on the edge that counts the last tick of the timeout.
- R6: A watchdog, illegal-opcode or illegal-address request seen outside reset starts a short reset lasting 32 ticks.
- R7: Short requests that arrive during a reset neither extend it nor get logged.
- R8: `reset_cause` accumulates one bit per accepted source: bit 0 power-on, bit 1 low supply, bit 2 watchdog, bit 3 illegal opcode, bit 4 illegal address. If several short requests are accepted together, all of them are logged. If a low-supply request arrives together with short requests, only the low-supply bit is logged.
- R9: `status_rd` clears `reset_cause` on the next edge, except that a bit set on that same edge survives.
- R10: `osc_en` is high whenever `sys_rst` is high. Outside reset it equals the inverse of `osc_off_req`.
- R11: The timeout counter advances only on edges where `osc_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected source clock |
| osc_tick | input | 1 | One-cycle strobe per raw oscillator cycle |
| por_req | input | 1 | Power-on request, asynchronous, active high |
| lvi_req | input | 1 | Low-supply reset request |
| wdog_req | input | 1 | Watchdog reset request |
| bad_op_req | input | 1 | Illegal-opcode reset request |
| bad_addr_req | input | 1 | Illegal-address reset request |
| status_rd | input | 1 | Read strobe that clears the cause record |
| osc_off_req | input | 1 | Request to stop the oscillator while running |
| sys_rst | output | 1 | Internal reset, active high |
| rst_pin_n | output | 1 | External reset pin drive, active low |
| bus_ph1 | output | 1 | First bus clock enable phase |
| bus_ph2 | output | 1 | Second bus clock enable phase |
| osc_en | output | 1 | Oscillator enable to the clock generator |
| reset_cause | output | 5 | Sticky reset source record |

## Verification
The hardest states to reach are the ones where two events overlap inside a timeout. Examples are a second low-supply request arriving 1000 cycles into a long timeout, and an illegal-opcode request arriving in the middle of a watchdog reset. The bench places these pulses at counted cycle offsets from the start of each reset. It then measures the low period of the pin against fixed lengths. Starving the tick strobe keeps the block in reset for as long as needed, and stepping the strobe every third cycle shows that the count follows ticks, not clocks.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_LONG = 2'd1, ST_SHORT = 2'd2} seq_state_t;

  localparam int SRC_N    = 5;
  localparam int SRC_POR  = 0;
  localparam int SRC_LVI  = 1;
  localparam int SRC_WDOG = 2;
  localparam int SRC_OP   = 3;
  localparam int SRC_ADDR = 4;

  // true when the count has reached the final tick of a window of lim ticks
  function automatic logic last_tick(logic [31:0] cnt, logic [31:0] lim);
    return cnt == lim - 32'd1;
  endfunction

  // advance a two-bit bus phase position
  function automatic logic [1:0] phase_step(logic [1:0] p);
    return p + 2'd1;
  endfunction
endpackage

// File: rtl/rcs_merge.sv
module rcs_merge
  import rcs_pkg::*;
(
  input  logic             lvi_req,
  input  logic             wdog_req,
  input  logic             bad_op_req,
  input  logic             bad_addr_req,
  output logic             short_any,
  output logic [SRC_N-1:0] long_bits,
  output logic [SRC_N-1:0] short_bits
);
  always_comb begin
    long_bits            = '0;
    long_bits[SRC_LVI]   = lvi_req;
    short_bits           = '0;
    short_bits[SRC_WDOG] = wdog_req;
    short_bits[SRC_OP]   = bad_op_req;
    short_bits[SRC_ADDR] = bad_addr_req;
    short_any            = |short_bits;
  end
endmodule

// File: rtl/rcs_timer.sv
module rcs_timer
  import rcs_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32
) (
  input  logic clk,
  input  logic por_req,
  input  logic lvi_req,
  input  logic short_any,
  input  logic tick,
  output logic in_reset,
  output logic short_take
);
  localparam int CNT_W = $clog2(LONG_CYC);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      limit;
  logic             window_done;

  assign in_reset    = (state != ST_RUN);
  assign short_take  = (state == ST_RUN) && short_any && !lvi_req;
  assign limit       = (state == ST_LONG) ? 32'(LONG_CYC) : 32'(SHORT_CYC);
  assign window_done = in_reset && tick && last_tick(32'(cnt), limit);

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      state <= ST_LONG;
      cnt   <= '0;
    end else if (lvi_req) begin
      state <= ST_LONG;
      cnt   <= '0;
    end else if (short_take) begin
      state <= ST_SHORT;
      cnt   <= '0;
    end else if (in_reset && tick) begin
      if (window_done) begin
        state <= ST_RUN;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_lvi_restart_R4: assert property (@(posedge clk) disable iff (por_req)
    lvi_req |=> (in_reset && cnt == '0));

  assert_release_on_last_tick_R5: assert property (@(posedge clk) disable iff (por_req)
    $fell(in_reset) |-> ($past(tick) && 32'($past(cnt)) == $past(limit) - 32'd1));

  assert_hold_without_tick_R11: assert property (@(posedge clk) disable iff (por_req)
    (in_reset && !tick && !lvi_req) |=> (in_reset && $stable(cnt)));

  assert_short_ignored_R7: assert property (@(posedge clk) disable iff (por_req)
    (in_reset && !lvi_req && short_any && tick) |=> (!in_reset || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/rcs_phase.sv
module rcs_phase
  import rcs_pkg::*;
(
  input  logic clk,
  input  logic por_req,
  input  logic run,
  output logic ph1,
  output logic ph2
);
  logic [1:0] pos;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)  pos <= 2'd0;
    else if (run) pos <= phase_step(pos);
    else          pos <= 2'd0;
  end

  assign ph1 = run && (pos == 2'd0);
  assign ph2 = run && (pos == 2'd2);

  assert_ph1_single_R1: assert property (@(posedge clk) disable iff (por_req)
    ph1 |=> (!ph1 && !ph2));

  assert_ph2_follows_R1: assert property (@(posedge clk) disable iff (por_req)
    ph2 |-> $past(ph1, 2));
endmodule

// File: rtl/rcs_status.sv
module rcs_status
  import rcs_pkg::*;
(
  input  logic             clk,
  input  logic             por_req,
  input  logic             rd,
  input  logic [SRC_N-1:0] set_mask,
  output logic [SRC_N-1:0] cause
);
  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) cause <= SRC_N'(1) << SRC_POR;
    else         cause <= (rd ? '0 : cause) | set_mask;
  end

  assert_set_survives_R9: assert property (@(posedge clk) disable iff (por_req)
    (|set_mask) |=> ((cause & $past(set_mask)) == $past(set_mask)));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (por_req)
    (rd && set_mask == '0) |=> (cause == '0));
endmodule

// File: rtl/rst_clk_seq.sv
module rst_clk_seq
  import rcs_pkg::*;
#(
  parameter int LONG_CYC  = 4096,
  parameter int SHORT_CYC = 32
) (
  input  logic             clk,
  input  logic             osc_tick,
  input  logic             por_req,
  input  logic             lvi_req,
  input  logic             wdog_req,
  input  logic             bad_op_req,
  input  logic             bad_addr_req,
  input  logic             status_rd,
  input  logic             osc_off_req,
  output logic             sys_rst,
  output logic             rst_pin_n,
  output logic             bus_ph1,
  output logic             bus_ph2,
  output logic             osc_en,
  output logic [SRC_N-1:0] reset_cause
);
  logic             short_any;
  logic             short_take;
  logic             in_reset;
  logic [SRC_N-1:0] long_bits;
  logic [SRC_N-1:0] short_bits;
  logic [SRC_N-1:0] set_mask;

  rcs_merge u_merge (
    .lvi_req(lvi_req), .wdog_req(wdog_req), .bad_op_req(bad_op_req),
    .bad_addr_req(bad_addr_req), .short_any(short_any),
    .long_bits(long_bits), .short_bits(short_bits)
  );

  rcs_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk(clk), .por_req(por_req), .lvi_req(lvi_req), .short_any(short_any),
    .tick(osc_tick), .in_reset(in_reset), .short_take(short_take)
  );

  rcs_phase u_phase (
    .clk(clk), .por_req(por_req), .run(!in_reset), .ph1(bus_ph1), .ph2(bus_ph2)
  );

  assign set_mask = long_bits | (short_take ? short_bits : '0);

  rcs_status u_status (
    .clk(clk), .por_req(por_req), .rd(status_rd), .set_mask(set_mask), .cause(reset_cause)
  );

  assign sys_rst   = in_reset;
  assign rst_pin_n = !in_reset;
  assign osc_en    = in_reset || !osc_off_req;

  assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (por_req)
    sys_rst |-> (!bus_ph1 && !bus_ph2));

  assert_osc_kept_R10: assert property (@(posedge clk) disable iff (por_req)
    sys_rst |-> osc_en);

  assert_lvi_logged_R8: assert property (@(posedge clk) disable iff (por_req)
    lvi_req |=> reset_cause[SRC_LVI]);
endmodule

// File: tb/sim_rst_clk_seq.sv
module sim_rst_clk_seq;
  logic clk = 1'b0;
  logic osc_tick = 1'b0, por_req = 1'b0, lvi_req = 1'b0, wdog_req = 1'b0;
  logic bad_op_req = 1'b0, bad_addr_req = 1'b0, status_rd = 1'b0, osc_off_req = 1'b0;
  logic sys_rst, rst_pin_n, bus_ph1, bus_ph2, osc_en;
  logic [4:0] reset_cause;

  rst_clk_seq u0 (
    .clk(clk), .osc_tick(osc_tick), .por_req(por_req), .lvi_req(lvi_req),
    .wdog_req(wdog_req), .bad_op_req(bad_op_req), .bad_addr_req(bad_addr_req),
    .status_rd(status_rd), .osc_off_req(osc_off_req), .sys_rst(sys_rst),
    .rst_pin_n(rst_pin_n), .bus_ph1(bus_ph1), .bus_ph2(bus_ph2), .osc_en(osc_en),
    .reset_cause(reset_cause)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // tick generator: period tick_mode cycles, 0 = no ticks
  int tick_mode = 1, tick_cyc = 0;
  always @(posedge clk) begin
    #1;
    osc_tick = (tick_mode != 0) && (tick_cyc % (tick_mode == 0 ? 1 : tick_mode) == 0);
    tick_cyc++;
  end

  // inputs as seen at the last rising edge
  logic s_por = 1'b0, s_lvi = 1'b0, s_wd = 1'b0, s_op = 1'b0, s_ad = 1'b0, s_rd = 1'b0, s_tick = 1'b0;
  always @(posedge clk) begin
    s_por <= por_req; s_lvi <= lvi_req; s_wd <= wdog_req; s_op <= bad_op_req;
    s_ad <= bad_addr_req; s_rd <= status_rd; s_tick <= osc_tick;
  end

  // behavioural reference: mode 0 running, 1 long wait, 2 short wait
  int m_mode = 1, m_cnt = 0, m_div = 0;
  logic [4:0] m_cause = 5'b00001;
  bit m_live = 0;

  always @(negedge clk) begin
    if (por_req || s_por) begin
      m_mode = 1; m_cnt = 0; m_div = 0; m_cause = 5'b00001; m_live = por_req || m_live;
    end else if (m_live) begin
      bit was_run;
      logic [4:0] nc;
      was_run = (m_mode == 0);
      nc = s_rd ? 5'b0 : m_cause;
      m_div = was_run ? (m_div + 1) % 4 : 0;
      if (s_lvi) begin
        m_mode = 1; m_cnt = 0; nc[1] = 1'b1;
      end else if (was_run && (s_wd || s_op || s_ad)) begin
        m_mode = 2; m_cnt = 0; nc = nc | {s_ad, s_op, s_wd, 2'b00};
      end else if (!was_run && s_tick) begin
        if (m_cnt == ((m_mode == 1) ? 4096 : 32) - 1) begin m_mode = 0; m_cnt = 0; end
        else m_cnt++;
      end
      m_cause = nc;
    end
    if (m_live) begin
      bit run;
      run = (m_mode == 0);
      check(rst_pin_n == run && sys_rst == !run, "R5 pin/reset vs model", int'(rst_pin_n), int'(run));
      check(bus_ph1 == (run && m_div == 0) && bus_ph2 == (run && m_div == 2),
            "R1 R2 bus phases vs model", int'({bus_ph1, bus_ph2}), int'({run && m_div == 0, run && m_div == 2}));
      check(reset_cause == m_cause, "R8 cause vs model", int'(reset_cause), int'(m_cause));
      check(osc_en == (!run || !osc_off_req), "R10 osc_en vs model", int'(osc_en), int'(!run || !osc_off_req));
    end
  end

  // length of each low period on the pin
  int low_cnt = 0, last_len = 0;
  always @(negedge clk) begin
    if (por_req) low_cnt = 0;
    else if (!rst_pin_n) low_cnt++;
    else if (low_cnt != 0) begin last_len = low_cnt; low_cnt = 0; end
  end

  // phase counters
  int n_ph1 = 0, n_ph2 = 0;
  always @(negedge clk) begin
    if (bus_ph1) n_ph1++;
    if (bus_ph2) n_ph2++;
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wait_release;
    for (int i = 0; i < 20000 && !rst_pin_n; i++) step();
    step(2);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  int wd_cyc = 0;
  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd_cyc, 0);
      finish_run();
    end
  end

  initial begin
    #1 por_req = 1'b1;
    step(3);
    check(reset_cause == 5'b00001, "R3 cause during power-on", int'(reset_cause), 1);
    check(!rst_pin_n && sys_rst, "R3 pin low during power-on", int'(rst_pin_n), 0);
    check(!bus_ph1 && !bus_ph2, "R2 no phases in power-on", int'({bus_ph1, bus_ph2}), 0);
    por_req = 1'b0;
    wait_release();
    check(last_len == 4096, "R3 R5 power-on timeout length", last_len, 4096);

    // R1: phase counting over 40 running cycles
    n_ph1 = 0; n_ph2 = 0;
    step(40);
    check(n_ph1 == 10 && n_ph2 == 10, "R1 phase count in 40 cycles", n_ph1 * 100 + n_ph2, 1010);

    // R10: oscillator off request while running
    osc_off_req = 1'b1; step(2);
    check(osc_en == 1'b0, "R10 osc off while running", int'(osc_en), 0);

    // R9: read clears
    status_rd = 1'b1; step(); status_rd = 1'b0; step();
    check(reset_cause == 5'b0, "R9 read clears cause", int'(reset_cause), 0);

    // R6 R7: watchdog short reset, illegal opcode mid-way ignored
    wdog_req = 1'b1; step(); wdog_req = 1'b0;
    step(2);
    check(osc_en == 1'b1, "R10 osc forced during reset", int'(osc_en), 1);
    step(8);
    bad_op_req = 1'b1; step(); bad_op_req = 1'b0;
    wait_release();
    check(last_len == 32, "R6 R7 short reset length", last_len, 32);
    check(reset_cause == 5'b00100, "R7 R8 only watchdog logged", int'(reset_cause), 4);
    osc_off_req = 1'b0;

    // R11: no ticks keeps reset, then ticks every third cycle
    status_rd = 1'b1; step(); status_rd = 1'b0;
    tick_mode = 0;
    bad_addr_req = 1'b1; step(); bad_addr_req = 1'b0;
    step(100);
    check(!rst_pin_n, "R11 held without ticks", int'(rst_pin_n), 0);
    check(reset_cause == 5'b10000, "R8 illegal address bit", int'(reset_cause), 16);
    tick_mode = 3;
    wait_release();
    check(rst_pin_n, "R11 released after slow ticks", int'(rst_pin_n), 1);
    tick_mode = 1;

    // R4: low-supply restart 1000 cycles in
    step(5);
    lvi_req = 1'b1; step(); lvi_req = 1'b0;
    step(999);
    lvi_req = 1'b1; step(); lvi_req = 1'b0;
    wait_release();
    check(last_len == 5096, "R4 restart extends timeout", last_len, 5096);

    // R9: read on the same edge as a new low-supply request
    status_rd = 1'b1; lvi_req = 1'b1; step();
    status_rd = 1'b0; lvi_req = 1'b0;
    check(reset_cause == 5'b00010, "R9 new bit survives read", int'(reset_cause), 2);
    wait_release();

    // R8: two short sources together
    status_rd = 1'b1; step(); status_rd = 1'b0;
    wdog_req = 1'b1; bad_addr_req = 1'b1; step(); wdog_req = 1'b0; bad_addr_req = 1'b0;
    step();
    check(reset_cause == 5'b10100, "R8 simultaneous sources", int'(reset_cause), 20);
    wait_release();

    // R8: low supply with a short source: only low supply logged
    status_rd = 1'b1; step(); status_rd = 1'b0;
    lvi_req = 1'b1; bad_op_req = 1'b1; step(); lvi_req = 1'b0; bad_op_req = 1'b0;
    step();
    check(reset_cause == 5'b00010, "R8 low supply wins", int'(reset_cause), 2);
    wait_release();

    // R3: power-on while running
    step(3);
    por_req = 1'b1; step(2);
    check(reset_cause == 5'b00001 && sys_rst, "R3 power-on resets cause", int'(reset_cause), 1);
    done = 1;
    finish_run();
  end
endmodule